// File: doc/BRIEF.md
# Paced Block-Transfer Sequencer

This block sequences repeated block transfers between a paced data path and a host through a 512-byte FIFO. Software writes a six-bit control word. The word selects the function, starts a run, chooses what the 16-bit down counter counts, and picks the continuous mode, the output-port double buffering and the error flags. While a run is active, the counter decrements once per pacer tick or once per half-full FIFO burst. A run ends when the counter reaches terminal count. In continuous mode it ends instead when software writes the arm register, and the counter is left holding a residual value that software can read.

The end of a run produces a one-cycle done pulse and a sticky interrupt request. Overrun and underrun flags record accesses to a full or an empty FIFO. Two 8-bit output ports either follow their register writes at once or are held and applied together on the next pacer tick.

Top module: `pxs_top`

## Requirements
- R1: After reset the count, the control readback, done, interrupt, both error flags and both output ports are all zero.
- R2: The control word uses bit 0 for mode, bit 1 for run, bit 2 for burst count, bit 3 for continuous, bit 4 for double buffer and bit 5 for error enable, and it reads back on `ctrl_o` with the same bit positions. Bit 1 reads back as set only while a run is active. A write with run and mode both set starts a run. A write with run set but mode clear leaves the block idle. Any control write with run clear stops a run without a done pulse.
- R3: With burst count clear, an active run decrements the counter once per `pace_i` cycle. While the block is idle, the counter holds its value unless it is loaded.
- R4: With burst count set, an active run decrements the counter once per rising edge of `fifo_half_i`, and `pace_i` does not move the counter.
- R5: When a non-continuous run decrements from 1 to 0, the run bit clears, `done_o` pulses high for exactly one cycle, and `irq_o` rises. Later pacer ticks leave the count at 0. `irq_o` stays high until `flag_clr_i` is asserted.
- R6: Starting a run with continuous set loads 16'hFFFF. An `arm_we_i` strobe then ends the run: the count freezes, `done_o` pulses and `irq_o` rises. An `arm_we_i` strobe during a non-continuous run has no effect.
- R7: When mode is clear, `irq_o` is low, and a control write that clears mode also clears a pending interrupt.
- R8: With error enable set, `ovr_o` sets on `host_wr_i` or on a pacer tick during a run while `fifo_full_i` is high. It stays set until `flag_clr_i` is asserted.
- R9: With error enable set, `unr_o` sets on `host_rd_i` while `fifo_empty_i` is high. It stays set until `flag_clr_i` is asserted.
- R10: With error enable clear, neither flag sets.
- R11: With double buffer clear, a write to a port appears on `port_o` on the next cycle. Port A is bits 7:0 and port B is bits 15:8.
- R12: With double buffer set, a port write is held until the next `pace_i` cycle and is then applied to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 6 | Control word data |
| cnt_we_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 16 | Counter load value |
| arm_we_i | input | 1 | Arm register write strobe |
| flag_clr_i | input | 1 | Clears the interrupt and both error flags |
| pace_i | input | 1 | Pacer tick, one cycle per sample |
| fifo_half_i | input | 1 | FIFO half-full status |
| fifo_full_i | input | 1 | FIFO full status |
| fifo_empty_i | input | 1 | FIFO empty status |
| host_rd_i | input | 1 | Host FIFO read strobe |
| host_wr_i | input | 1 | Host FIFO write strobe |
| port_we_i | input | 2 | Port write strobes, bit 0 is port A |
| port_wdata_i | input | 8 | Port write data |
| cnt_o | output | 16 | Counter value |
| ctrl_o | output | 6 | Control word readback with the live run bit |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| irq_o | output | 1 | Interrupt request |
| ovr_o | output | 1 | Overrun flag |
| unr_o | output | 1 | Underrun flag |
| port_o | output | 16 | Output ports, A in 7:0, B in 15:8 |

## Verification
The assertions check on every cycle that an idle counter holds its value, that a terminal count or an arm strobe stops the run and pulses done exactly once, that the error flags stay set until cleared and never set while errors are disabled, and that the port outputs follow the direct or held update rule. Only the bench scenarios can show that the decrement comes from the selected event source, that the continuous-mode preload is 16'hFFFF, that a run will not start without the mode bit, and how a control write that clears mode affects a pending interrupt.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int unsigned CB_MODE  = 0;
  localparam int unsigned CB_RUN   = 1;
  localparam int unsigned CB_BURST = 2;
  localparam int unsigned CB_CONT  = 3;
  localparam int unsigned CB_DBL   = 4;
  localparam int unsigned CB_ERR   = 5;
  localparam int unsigned CTRL_W   = 6;

  typedef struct packed {
    logic err_en;
    logic dbl;
    logic cont;
    logic burst;
    logic mode;
  } cfg_t;
endpackage

// File: rtl/pxs_counter.sv
module pxs_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             burst_i,
  input  logic             cont_i,
  input  logic             ctrl_wr_i,
  input  logic             wr_mode_i,
  input  logic             wr_run_i,
  input  logic             wr_cont_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             pace_i,
  input  logic             half_rise_i,
  input  logic             arm_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             done_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic run_q, done_q, irq_q;
  logic dec_ev, tc_ev, arm_ev, start_ev;

  assign start_ev = ctrl_wr_i & wr_mode_i & wr_run_i;
  assign dec_ev   = run_q & ~ctrl_wr_i & (burst_i ? half_rise_i : pace_i);
  assign tc_ev    = dec_ev & ~cont_i & (cnt_q == CNT_W'(1));
  assign arm_ev   = run_q & ~ctrl_wr_i & cont_i & arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr_i)            run_q <= wr_mode_i & wr_run_i;
      else if (tc_ev || arm_ev) run_q <= 1'b0;

      // continuous start preloads all ones; arm freezes the residual count
      if (start_ev && wr_cont_i)  cnt_q <= '1;
      else if (load_i)            cnt_q <= load_val_i;
      else if (dec_ev && !arm_ev) cnt_q <= cnt_q - CNT_W'(1);

      done_q <= tc_ev | arm_ev;

      if (!mode_i)              irq_q <= 1'b0;
      else if (tc_ev || arm_ev) irq_q <= 1'b1;
      else if (irq_clr_i)       irq_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign done_o = done_q;
  assign irq_o  = irq_q & mode_i;

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i && !ctrl_wr_i) |=> $stable(cnt_q));
  a_r5_tc_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_ev && !load_i) |=> (cnt_q == '0 && !run_q && done_q));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r6_arm_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_ev && !load_i) |=> ($stable(cnt_q) && !run_q && irq_q));
endmodule

// File: rtl/pxs_err.sv
module pxs_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_en_i,
  input  logic run_i,
  input  logic pace_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic host_rd_i,
  input  logic host_wr_i,
  input  logic clr_i,
  output logic ovr_o,
  output logic unr_o
);
  logic ovr_q, unr_q;
  logic ovr_set, unr_set;

  assign ovr_set = err_en_i & full_i & (host_wr_i | (pace_i & run_i));
  assign unr_set = err_en_i & empty_i & host_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      unr_q <= 1'b0;
    end else begin
      if (clr_i)        ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      if (clr_i)        unr_q <= 1'b0;
      else if (unr_set) unr_q <= 1'b1;
    end
  end

  assign ovr_o = ovr_q;
  assign unr_o = unr_q;

  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  a_r9_unr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_en_i && empty_i && host_rd_i && !clr_i) |=> unr_q);
  a_r10_ovr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_en_i && !ovr_q) |=> !ovr_q);
  a_r10_unr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_en_i && !unr_q) |=> !unr_q);
endmodule

// File: rtl/pxs_port.sv
module pxs_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dbl_i,
  input  logic         pace_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (we_i) hold_q <= wdata_i;
      if (!dbl_i && we_i)      out_q <= wdata_i;
      else if (dbl_i && pace_i) out_q <= hold_q;
    end
  end

  assign q_o = out_q;

  a_r11_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_i && we_i) |=> (out_q == $past(wdata_i)));
  a_r12_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i && !pace_i) |=> $stable(out_q));
endmodule

// File: rtl/pxs_top.sv
module pxs_top
  import pxs_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned NPORT  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctrl_we_i,
  input  logic [CTRL_W-1:0]       ctrl_wdata_i,
  input  logic                    cnt_we_i,
  input  logic [CNT_W-1:0]        cnt_wdata_i,
  input  logic                    arm_we_i,
  input  logic                    flag_clr_i,
  input  logic                    pace_i,
  input  logic                    fifo_half_i,
  input  logic                    fifo_full_i,
  input  logic                    fifo_empty_i,
  input  logic                    host_rd_i,
  input  logic                    host_wr_i,
  input  logic [NPORT-1:0]        port_we_i,
  input  logic [PORT_W-1:0]       port_wdata_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CTRL_W-1:0]       ctrl_o,
  output logic                    done_o,
  output logic                    irq_o,
  output logic                    ovr_o,
  output logic                    unr_o,
  output logic [NPORT*PORT_W-1:0] port_o
);
  cfg_t cfg_q;
  logic half_q, half_rise, run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      half_q <= 1'b0;
    end else begin
      half_q <= fifo_half_i;
      if (ctrl_we_i) begin
        cfg_q.mode   <= ctrl_wdata_i[CB_MODE];
        cfg_q.burst  <= ctrl_wdata_i[CB_BURST];
        cfg_q.cont   <= ctrl_wdata_i[CB_CONT];
        cfg_q.dbl    <= ctrl_wdata_i[CB_DBL];
        cfg_q.err_en <= ctrl_wdata_i[CB_ERR];
      end
    end
  end

  assign half_rise = fifo_half_i & ~half_q;

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[CB_MODE]  = cfg_q.mode;
    ctrl_o[CB_RUN]   = run;
    ctrl_o[CB_BURST] = cfg_q.burst;
    ctrl_o[CB_CONT]  = cfg_q.cont;
    ctrl_o[CB_DBL]   = cfg_q.dbl;
    ctrl_o[CB_ERR]   = cfg_q.err_en;
  end

  pxs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (cfg_q.mode),
    .burst_i     (cfg_q.burst),
    .cont_i      (cfg_q.cont),
    .ctrl_wr_i   (ctrl_we_i),
    .wr_mode_i   (ctrl_wdata_i[CB_MODE]),
    .wr_run_i    (ctrl_wdata_i[CB_RUN]),
    .wr_cont_i   (ctrl_wdata_i[CB_CONT]),
    .load_i      (cnt_we_i),
    .load_val_i  (cnt_wdata_i),
    .pace_i      (pace_i),
    .half_rise_i (half_rise),
    .arm_i       (arm_we_i),
    .irq_clr_i   (flag_clr_i),
    .cnt_o       (cnt_o),
    .run_o       (run),
    .done_o      (done_o),
    .irq_o       (irq_o)
  );

  pxs_err u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_en_i  (cfg_q.err_en),
    .run_i     (run),
    .pace_i    (pace_i),
    .full_i    (fifo_full_i),
    .empty_i   (fifo_empty_i),
    .host_rd_i (host_rd_i),
    .host_wr_i (host_wr_i),
    .clr_i     (flag_clr_i),
    .ovr_o     (ovr_o),
    .unr_o     (unr_o)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pxs_port #(.W(PORT_W)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dbl_i   (cfg_q.dbl),
      .pace_i  (pace_i),
      .we_i    (port_we_i[g]),
      .wdata_i (port_wdata_i),
      .q_o     (port_o[g*PORT_W +: PORT_W])
    );
  end

  a_r7_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_wdata_i[CB_MODE]) |=> !irq_o);
endmodule

// File: tb/pxs_top_bench.sv
module pxs_top_bench;
  localparam logic [5:0] MODE = 6'h01, RUN = 6'h02, BURST = 6'h04,
                         CONT = 6'h08, DBL = 6'h10, ERR = 6'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, cnt_we = 0, arm_we = 0, flag_clr = 0, pace = 0;
  logic half = 0, full = 0, empty = 0, hrd = 0, hwr = 0;
  logic [5:0]  ctrl_wd = '0;
  logic [15:0] cnt_wd = '0;
  logic [1:0]  port_we = '0;
  logic [7:0]  port_wd = '0;
  logic [15:0] cnt, port;
  logic [5:0]  ctrl;
  logic done, irq, ovr, unr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pxs_top u_pxs_top (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .arm_we_i(arm_we),
    .flag_clr_i(flag_clr), .pace_i(pace), .fifo_half_i(half),
    .fifo_full_i(full), .fifo_empty_i(empty), .host_rd_i(hrd),
    .host_wr_i(hwr), .port_we_i(port_we), .port_wdata_i(port_wd),
    .cnt_o(cnt), .ctrl_o(ctrl), .done_o(done), .irq_o(irq),
    .ovr_o(ovr), .unr_o(unr), .port_o(port)
  );

  // {pace, expected run bit, expected count}, sample mode from a count of 3
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b1, 16'd3}, {1'b1, 1'b1, 16'd2}, {1'b0, 1'b1, 16'd2},
    {1'b1, 1'b1, 16'd1}, {1'b1, 1'b0, 16'd0}, {1'b1, 1'b0, 16'd0}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [5:0] v);
    ctrl_we = 1; ctrl_wd = v; cyc(); ctrl_we = 0;
  endtask

  task automatic load(logic [15:0] v);
    cnt_we = 1; cnt_wd = v; cyc(); cnt_we = 0;
  endtask

  task automatic tick();
    pace = 1; cyc(); pace = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 ctrl", 32'(ctrl), 0);
    chk("R1 flags", {28'd0, done, irq, ovr, unr}, 0);
    chk("R1 ports", 32'(port), 0);
    rst_n = 1; cyc();

    // R2 run needs mode; readback positions; stop without done
    wr_ctrl(RUN);
    chk("R2 no mode", 32'(ctrl), 0);
    wr_ctrl(MODE | RUN | ERR);
    chk("R2 readback", 32'(ctrl), 32'h23);
    wr_ctrl(MODE);
    chk("R2 stop", 32'(ctrl), 32'h01);
    chk("R2 no done", 32'(done), 0);

    // R3 sample counting via vector table
    load(16'd3);
    wr_ctrl(MODE | RUN);
    for (int i = 0; i < 6; i++) begin
      pace = VEC[i][17]; cyc(); pace = 0;
      chk("R3 cnt", 32'(cnt), 32'(VEC[i][15:0]));
      chk("R3 run", 32'(ctrl[1]), 32'(VEC[i][16]));
    end
    load(16'd7); cyc();
    chk("R3 idle hold", 32'(cnt), 7);

    // R5 terminal count
    load(16'd1);
    wr_ctrl(MODE | RUN);
    tick();
    chk("R5 cnt", 32'(cnt), 0);
    chk("R5 done", 32'(done), 1);
    chk("R5 irq", 32'(irq), 1);
    chk("R5 run clr", 32'(ctrl[1]), 0);
    tick();
    chk("R5 done pulse", 32'(done), 0);
    chk("R5 ignore tick", 32'(cnt), 0);
    chk("R5 irq held", 32'(irq), 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R5 irq clr", 32'(irq), 0);

    // R4 burst counting
    load(16'd2);
    wr_ctrl(MODE | RUN | BURST);
    half = 1; cyc();
    chk("R4 half rise", 32'(cnt), 1);
    cyc();
    chk("R4 half level", 32'(cnt), 1);
    tick();
    chk("R4 pace ignored", 32'(cnt), 1);
    half = 0; cyc(); half = 1; cyc();
    chk("R4 second rise", 32'(cnt), 0);
    chk("R4 done", 32'(done), 1);
    half = 0; flag_clr = 1; cyc(); flag_clr = 0;

    // R6 arm ignored outside continuous
    load(16'd4);
    wr_ctrl(MODE | RUN);
    arm_we = 1; cyc(); arm_we = 0;
    chk("R6 arm ignored run", 32'(ctrl[1]), 1);
    chk("R6 arm ignored cnt", 32'(cnt), 4);
    // R6 continuous residual
    wr_ctrl(MODE | RUN | CONT);
    chk("R6 preload", 32'(cnt), 32'hFFFF);
    tick(); tick(); tick();
    chk("R6 residual", 32'(cnt), 32'hFFFC);
    arm_we = 1; cyc(); arm_we = 0;
    chk("R6 arm done", 32'(done), 1);
    chk("R6 arm irq", 32'(irq), 1);
    chk("R6 arm run", 32'(ctrl[1]), 0);
    tick();
    chk("R6 frozen", 32'(cnt), 32'hFFFC);

    // R7 mode clear drops interrupt
    wr_ctrl(6'h00);
    chk("R7 irq off", 32'(irq), 0);
    wr_ctrl(MODE);
    chk("R7 irq cleared", 32'(irq), 0);

    // R10 errors disabled
    full = 1; empty = 1; hwr = 1; hrd = 1; cyc(); hwr = 0; hrd = 0;
    chk("R10 ovr", 32'(ovr), 0);
    chk("R10 unr", 32'(unr), 0);

    // R8 overrun
    wr_ctrl(ERR);
    tick();
    chk("R8 idle pace", 32'(ovr), 0);
    hwr = 1; cyc(); hwr = 0;
    chk("R8 host wr", 32'(ovr), 1);
    cyc();
    chk("R8 sticky", 32'(ovr), 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R8 clr", 32'(ovr), 0);
    load(16'd9);
    wr_ctrl(ERR | MODE | RUN);
    tick();
    chk("R8 run pace", 32'(ovr), 1);

    // R9 underrun
    hrd = 1; cyc(); hrd = 0;
    chk("R9 set", 32'(unr), 1);
    empty = 0; cyc();
    chk("R9 sticky", 32'(unr), 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R9 clr", 32'(unr), 0);
    full = 0;

    // R11 direct ports
    wr_ctrl(6'h00);
    port_we = 2'b01; port_wd = 8'hAA; cyc(); port_we = 0;
    chk("R11 port A", 32'(port), 32'h00AA);

    // R12 double buffered
    wr_ctrl(DBL);
    port_we = 2'b10; port_wd = 8'h55; cyc(); port_we = 0;
    chk("R12 held", 32'(port), 32'h00AA);
    cyc();
    chk("R12 still held", 32'(port), 32'h00AA);
    tick();
    chk("R12 applied", 32'(port), 32'h55AA);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule